// File: doc/BRIEF.md
# SPI Master Word Shifter

This block serializes one word at a time onto a single-lane SPI bus as the bus master. A 16-bit command word sets the word length, clock idle level, clock phase, chip-select behaviour and the two data-direction enables. Once the command is loaded, a single-cycle `start` pulse captures `tx_word` and runs one word of 1 to 32 bits on `sclk`/`mosi`, sampling `miso` at the same time. When receive is enabled, the captured word is presented on a valid/ready output.

The SCLK half-period is a compile-time count of system clocks (`HALF_PERIOD`, minimum 1). Command layout (bit positions): [4:0] length minus one, [6:5] idle code, [7] phase, [11:8] chip-select enables (line n at bit 8+n), [12] software chip-select mode, [13] software chip-select value, [14] transmit enable, [15] receive enable. In software mode the chip-select lines can be held across several words and released by rewriting the command. The resting command is 16'h1000.

Top module: `spi_word_shifter`

## Requirements
- R1: A word has (cmd[4:0] + 1) bits and is shifted out most significant bit first. With transmit enabled (cmd[14]=1), `mosi` carries the low N bits of `tx_word` at each sampling edge.
- R2: With receive enabled (cmd[15]=1), the N sampled `miso` bits appear right-aligned and zero-extended on `rx_data`. `rx_valid` rises in the cycle `busy` falls and, together with `rx_data`, holds until `rx_ready` is seen high.
- R3: When idle, `sclk` rests low for idle codes 0 and 2 and high for codes 1 and 3. It returns to that level at the end of every word.
- R4: With phase bit cmd[7]=0, the first bit is on `mosi` before the first SCLK edge and `miso` is sampled on leading edges. With cmd[7]=1, data is launched on leading edges and sampled on trailing edges.
- R5: In software mode (cmd[12]=1), `cs_n[n]` is low exactly when enable bit cmd[8+n] and value bit cmd[13] are both 1. The level holds during words and between them until the command is rewritten.
- R6: In hardware mode (cmd[12]=0), the enabled lines are low only while `busy` is high. All lines are high otherwise.
- R7: With transmit disabled, the word still runs but `mosi` stays low.
- R8: With receive disabled, no `rx_valid` is produced.
- R9: `busy` rises in the cycle after `start` is accepted and stays high for exactly 2·N·HALF_PERIOD cycles. A `start` pulse during `busy` is ignored.
- R10: A command write during `busy` is ignored. Writing 16'h1000 when idle releases all chip-select lines.
- R11: After reset: `busy`=0, `rx_valid`=0, `cs_n`=4'hF, `sclk`=0, `mosi`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr | input | 1 | Load `cmd_in` into the command register when idle |
| cmd_in | input | 16 | Command word |
| start | input | 1 | Begin one word when idle |
| tx_word | input | 32 | Word to transmit, right-aligned |
| busy | output | 1 | Word in progress |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Active-low chip-select lines |
| rx_valid | output | 1 | Received word available |
| rx_ready | input | 1 | Consumer accepts the received word |
| rx_data | output | 32 | Received word, zero-extended |

## Verification
`busy` is due one clock after the edge that samples `start`, and it falls 2·N·HALF_PERIOD clocks later. The bench counts falling clock edges between those two points and compares the count with that figure. `rx_valid`, `rx_data` and the final `sclk` level are due in the same cycle that `busy` falls. The bench waits one more falling edge before reading them, so that the slave model's last sample has also settled. Chip-select is checked one cycle into the word and again once the word has ended. Every check is taken on the falling clock edge.

// File: rtl/spi_word_shifter.sv
module spi_word_shifter #(
  parameter int HALF_PERIOD = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_wr,
  input  logic [15:0] cmd_in,
  input  logic        start,
  input  logic [31:0] tx_word,
  output logic        busy,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic [3:0]  cs_n,
  output logic        rx_valid,
  input  logic        rx_ready,
  output logic [31:0] rx_data
);
  localparam int CW = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;
  localparam logic [15:0] REST_CMD = 16'h1000;

  logic [15:0]   cmd_q;
  logic          busy_q, act_q, mosi_q, rx_valid_q;
  logic [CW-1:0] div_q;
  logic [5:0]    edge_q;
  logic [31:0]   tx_sr, rx_sr, rx_data_q;

  wire [4:0] len_m1  = cmd_q[4:0];
  wire       idle_hi = (cmd_q[6:5] == 2'd1) || (cmd_q[6:5] == 2'd3);
  wire       cpha    = cmd_q[7];
  wire [3:0] cs_en   = cmd_q[11:8];
  wire       cs_sw   = cmd_q[12];
  wire       cs_val  = cmd_q[13];
  wire       tx_en   = cmd_q[14];
  wire       rx_en   = cmd_q[15];

  wire        tick      = busy_q && (div_q == CW'(HALF_PERIOD - 1));
  wire        last_edge = edge_q == {len_m1, 1'b1};
  wire        samp_edge = edge_q[0] == cpha;
  wire [31:0] aligned   = tx_en ? (tx_word << (5'd31 - len_m1)) : 32'd0;
  wire [31:0] rx_next   = {rx_sr[30:0], miso};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q      <= REST_CMD;
      busy_q     <= 1'b0;
      act_q      <= 1'b0;
      mosi_q     <= 1'b0;
      div_q      <= '0;
      edge_q     <= '0;
      tx_sr      <= '0;
      rx_sr      <= '0;
      rx_valid_q <= 1'b0;
      rx_data_q  <= '0;
    end else begin
      if (cmd_wr && !busy_q) cmd_q <= cmd_in;
      if (rx_ready) rx_valid_q <= 1'b0;
      if (start && !busy_q) begin
        busy_q <= 1'b1;
        act_q  <= 1'b0;
        div_q  <= '0;
        edge_q <= '0;
        rx_sr  <= '0;
        if (cpha) begin
          tx_sr  <= aligned;
          mosi_q <= 1'b0;
        end else begin
          tx_sr  <= aligned << 1;
          mosi_q <= aligned[31];
        end
      end else if (busy_q) begin
        if (tick) begin
          div_q  <= '0;
          edge_q <= edge_q + 6'd1;
          act_q  <= ~act_q;
          if (samp_edge) rx_sr <= rx_next;
          else begin
            mosi_q <= tx_sr[31];
            tx_sr  <= tx_sr << 1;
          end
          if (last_edge) begin
            busy_q <= 1'b0;
            if (rx_en) begin
              rx_valid_q <= 1'b1;
              rx_data_q  <= cpha ? rx_next : rx_sr;
            end
          end
        end else begin
          div_q <= div_q + CW'(1);
        end
      end
    end
  end

  assign busy     = busy_q;
  assign sclk     = idle_hi ^ act_q;
  assign mosi     = mosi_q;
  assign rx_valid = rx_valid_q;
  assign rx_data  = rx_data_q;
  assign cs_n     = ~(cs_sw ? (cs_en & {4{cs_val}}) : (busy_q ? cs_en : 4'h0));
endmodule

// File: rtl/spi_word_shifter_chk.sv
module spi_word_shifter_chk #(
  parameter int HALF_PERIOD = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cmd,
  input logic        busy,
  input logic        sclk,
  input logic [3:0]  cs_n,
  input logic        rx_valid,
  input logic        rx_ready,
  input logic [31:0] rx_data
);
  logic [15:0] busy_cnt;
  wire  [15:0] want_cnt = 16'((32'(cmd[4:0]) + 1) * 2 * HALF_PERIOD);
  wire         idle_lvl = cmd[5];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_cnt <= '0;
    else if (!busy) busy_cnt <= '0;
    else busy_cnt <= busy_cnt + 16'd1;
  end

  // R9
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> busy_cnt == want_cnt);

  // R3
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sclk == idle_lvl);

  // R6
  hw_cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cmd[12]) |-> cs_n == 4'hF);

  // R8
  rx_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid) |-> ($fell(busy) && cmd[15]));

  // R2
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready && !busy) |=> (rx_valid && $stable(rx_data)));

  // R5
  sw_cs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd[12] && busy) |=> $stable(cs_n));
endmodule

bind spi_word_shifter spi_word_shifter_chk #(.HALF_PERIOD(HALF_PERIOD)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd(cmd_q), .busy(busy), .sclk(sclk),
  .cs_n(cs_n), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data)
);

// File: tb/test_spi_word_shifter.sv
module test_spi_word_shifter;
  localparam int HP = 2;

  logic        clk = 0, rst_n = 0;
  logic        cmd_wr = 0, start = 0, miso = 0, rx_ready = 0;
  logic [15:0] cmd_in = 16'h0;
  logic [31:0] tx_word = 0;
  logic        busy, sclk, mosi, rx_valid;
  logic [3:0]  cs_n;
  logic [31:0] rx_data;

  int errs = 0, checks = 0;

  logic [31:0] s_word = 0, mcap = 0;
  int          s_n = 1, ec = 0, k = 0;
  logic        s_cpha = 0, sp = 0;

  always #5 clk = ~clk;

  spi_word_shifter #(.HALF_PERIOD(HP)) i_spi_word_shifter (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_in(cmd_in), .start(start),
    .tx_word(tx_word), .busy(busy), .sclk(sclk), .mosi(mosi), .miso(miso),
    .cs_n(cs_n), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data)
  );

  // slave model: presents miso and captures mosi on the proper edges
  always @(negedge clk) begin
    if (sclk !== sp) begin
      sp = sclk;
      ec = ec + 1;
      if ((ec % 2) == (s_cpha ? 0 : 1)) mcap = {mcap[30:0], mosi};
      else begin
        k = s_cpha ? (ec - 1) / 2 : ec / 2;
        if (k < s_n) miso = s_word[s_n-1-k];
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mask(int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 32'h1);
  endfunction

  function automatic logic [3:0] cs_exp(logic [15:0] c, bit in_word);
    if (c[12]) return ~(c[11:8] & {4{c[13]}});
    return in_word ? ~c[11:8] : 4'hF;
  endfunction

  task automatic wcmd(logic [15:0] c);
    @(posedge clk); #1 cmd_wr = 1; cmd_in = c;
    @(posedge clk); #1 cmd_wr = 0;
  endtask

  task automatic run(logic [15:0] c, logic [31:0] tx, logic [31:0] sw, bit poke);
    int n, cnt;
    n = int'(c[4:0]) + 1;
    s_word = sw; s_n = n; s_cpha = c[7];
    wcmd(c);
    @(negedge clk);
    chk("R3 idle level after command", {31'd0, sclk}, {31'd0, c[6:5] == 2'd1 || c[6:5] == 2'd3});
    @(posedge clk); #1
    ec = 0; sp = sclk; mcap = 0;
    miso = c[7] ? 1'b0 : sw[n-1];
    tx_word = tx; start = 1;
    @(posedge clk); #1 start = 0;
    cnt = 0;
    while (cnt < 5000) begin
      @(negedge clk);
      if (!busy) break;
      cnt++;
      if (cnt == 1) chk("R5/R6 cs during word", {28'd0, cs_n}, {28'd0, cs_exp(c, 1)});
      if (poke && cnt == 3) begin start = 1; cmd_wr = 1; cmd_in = ~c; end
      if (poke && cnt == 4) begin start = 0; cmd_wr = 0; end
    end
    chk("R9 busy length", cnt, 2 * n * HP);
    @(negedge clk);
    chk("R1/R7/R4 mosi bits", mcap, c[14] ? (tx & mask(n)) : 32'd0);
    chk("R2/R8 rx_valid", {31'd0, rx_valid}, {31'd0, c[15]});
    if (c[15]) chk("R2/R4 rx_data", rx_data, sw & mask(n));
    chk("R3 sclk back to idle", {31'd0, sclk}, {31'd0, c[6:5] == 2'd1 || c[6:5] == 2'd3});
    chk("R5/R6/R10 cs after word", {28'd0, cs_n}, {28'd0, cs_exp(c, 0)});
    if (c[15]) begin
      repeat (3) @(negedge clk);
      chk("R2 rx_valid holds", {31'd0, rx_valid}, 32'd1);
      @(posedge clk); #1 rx_ready = 1;
      @(posedge clk); #1 rx_ready = 0;
      @(negedge clk);
      chk("R2 rx_valid cleared", {31'd0, rx_valid}, 32'd0);
    end
  endtask

  initial begin
    #1000000;
    errs++; checks++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk("R11 busy", {31'd0, busy}, 32'd0);
    chk("R11 rx_valid", {31'd0, rx_valid}, 32'd0);
    chk("R11 cs_n", {28'd0, cs_n}, 32'hF);
    chk("R11 sclk/mosi", {30'd0, sclk, mosi}, 32'd0);

    run(16'hF107, 32'h0000_00A5, 32'h0000_003C, 0);
    run(16'hF200, 32'h0000_0001, 32'h0000_0001, 0);
    run(16'hF4BF, 32'hDEAD_BEEF, 32'h8123_4567, 0);
    run(16'hF8CC, 32'h0000_0ABC, 32'h0000_0F0F, 0);
    run(16'hF165, 32'h0000_002B, 32'h0000_0015, 0);
    run(16'hB10F, 32'h0000_FFFF, 32'h0000_1234, 0);
    run(16'h710F, 32'h0000_5A5A, 32'h0000_FFFF, 0);
    run(16'hCF09, 32'h0000_0155, 32'h0000_02AA, 0);
    run(16'hF30B, 32'h0000_0C3A, 32'h0000_0777, 1);

    // R10 resting command releases every line
    wcmd(16'h1000);
    @(negedge clk);
    chk("R10 rest command releases cs", {28'd0, cs_n}, 32'hF);

    for (int i = 0; i < 24; i++) begin
      logic [15:0] c;
      c = 16'($urandom);
      if (c[4:0] == 5'd0) c[4:0] = 5'd1;
      run(c, $urandom, $urandom, (i % 3) == 0);
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule